// File: doc/BRIEF.md
# Compare-Match Reload Timer

This block is one 16-bit timer channel. A prescaler divides the system clock by a power of two chosen per channel, and the counter steps up by one on each divided tick. The counter starts from a programmable reload value. When it reaches a programmable compare value, the block raises a sticky interrupt flag and reloads the counter on that same tick.

In one-shot mode the channel stops itself after the first match. In interval mode it reloads and keeps counting, which gives a periodic request. The period is (compare − reload + 1) ticks, taken modulo 2^16.

Software reaches the channel through a small word-wide register port. Writes land on a clock edge and reads are combinational. A new reload or compare value written while the channel runs is used only from the next reload event. This means a period already in progress is never cut short or stretched.

Top module: `match_reload_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero (address 0 control, 1 reload, 2 compare, 3 count, 4 status), the timer is stopped and `irq` is low.
- R2: Control bits [4:2] select the prescale. The counter advances once every 2^sel system cycles while running (sel 0..7 gives 1..128). With sel = s, the k-th tick after a start falls on the (k·2^s)-th rising edge after the start edge.
- R3: On a tick where count equals the active compare value, status bit 0 sets and the counter loads the reload value on that same tick. One period therefore lasts ((compare − reload) mod 2^16) + 1 ticks.
- R4: Writing control bit 0 (run) to 1 while stopped loads the counter from the reload register and the active compare from the compare register on that edge, and restarts the prescaler.
- R5: With control bit 1 (mode) at 0 (one-shot), run clears by hardware on the matching tick, and the counter then holds the reload value.
- R6: With mode at 1 (interval), run stays set after a match and matches repeat every period.
- R7: Status bit 0 is sticky. Writing 1 to it at address 4 clears it, writing 0 leaves it, and a match in the same cycle wins over a clear. `irq` is status bit 0 AND control bit 5 (interrupt enable).
- R8: Compare and reload writes made while running do not change the period in progress. They take effect at the next reload event.
- R9: Writing run to 0 stops the counter. The count then holds its value, including through later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 ctrl, 1 reload, 2 compare, 3 count, 4 status) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, level, gated by enable |

## Verification
A start write lands on edge k, and the count reads the reload value from the following half cycle. A match is due exactly (period·2^sel) edges after the start edge. The bench tracks elapsed edges from the start write: it reads status one edge before the due edge to see it still clear, then reads again just after the due edge to see it set, with `irq` and run updated alongside. Register writes cost one edge each, and the bench counts that edge in its elapsed time. All reads are taken one time unit after a falling edge.

// File: rtl/mrt_pkg.sv
`timescale 1ns/1ps
// Package: register addresses and control-bit positions shared by the
// timer and its checker. Assumes a 3-bit word address space.
package mrt_pkg;
    typedef enum logic [2:0] {
        ADR_CTRL    = 3'd0,
        ADR_RELOAD  = 3'd1,
        ADR_COMPARE = 3'd2,
        ADR_COUNT   = 3'd3,
        ADR_STATUS  = 3'd4
    } mrt_addr_e;

    localparam int CTL_RUN  = 0;
    localparam int CTL_MODE = 1;
    localparam int CTL_SEL  = 2;
    localparam int CTL_IE   = 5;
endpackage

// File: rtl/mrt_prescaler.sv
`timescale 1ns/1ps
// Prescaler: free-running divider that is held at zero while the channel is
// stopped. It emits a one-cycle tick every 2^sel cycles while running.
// Assumes sel is stable while running, except for deliberate reprogramming.
module mrt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Mask has the low 'sel' bits set; one bit per generated slice.
    for (genvar g = 0; g < PRE_W; g++) begin : g_mask
        assign mask[g] = (32'(sel) > g);
    end

    assign tick = run && ((pre_q & mask) == mask);

    // Divider state: cleared while stopped, counts every cycle while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/mrt_counter.sv
`timescale 1ns/1ps
// Counter: up-counter with an active compare shadow. It loads the reload
// value and the compare shadow on start or on match, and steps on tick.
// Assumes start and tick are never high together.
module mrt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] compare_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp_act,
    output logic             match_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;

    assign match_evt = tick && (cnt_q == cmp_q);
    assign cnt       = cnt_q;
    assign cmp_act   = cmp_q;

    // Count register and compare shadow update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else if (start || match_evt) begin
            cnt_q <= reload_val;
            cmp_q <= compare_val;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mrt_irq_flag.sv
`timescale 1ns/1ps
// Interrupt flag: sticky status bit with write-one-to-clear. A set in the
// same cycle as a clear wins. Assumes set is a single-cycle pulse.
module mrt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Sticky status update, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/match_reload_timer.sv
`timescale 1ns/1ps
// Top: one compare-match reload timer channel with its register port.
// It holds control, reload and compare registers, decodes writes, muxes
// reads and sequences one-shot and interval modes. Assumes one register
// access per cycle and synchronous active-low reset.
module match_reload_timer #(
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 3,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);
    import mrt_pkg::*;

    localparam int CTL_W = CTL_IE + 1;

    logic             run_q, mode_q, ie_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] reload_q, compare_q;
    logic [CNT_W-1:0] cnt_w, cmp_act_w;
    logic             tick, match_evt, status_q;
    logic             wr_ctrl, wr_status, start;

    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(ADR_CTRL));
    assign wr_status = reg_wr && (reg_addr == ADDR_W'(ADR_STATUS));
    assign start     = wr_ctrl && reg_wdata[CTL_RUN] && !run_q;

    // Control register; a one-shot match clears run over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= 1'b0;
            sel_q  <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= reg_wdata[CTL_MODE];
                sel_q  <= reg_wdata[CTL_SEL +: SEL_W];
                ie_q   <= reg_wdata[CTL_IE];
            end
            if (match_evt && !mode_q) run_q <= 1'b0;
            else if (wr_ctrl)         run_q <= reg_wdata[CTL_RUN];
        end
    end

    // Software-visible reload and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q  <= '0;
            compare_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(ADR_RELOAD))  reload_q  <= reg_wdata;
            if (reg_addr == ADDR_W'(ADR_COMPARE)) compare_q <= reg_wdata;
        end
    end

    mrt_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk (clk),
        .rst_n (rst_n),
        .run (run_q),
        .sel (sel_q),
        .tick (tick)
    );

    mrt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start       (start),
        .reload_val  (reload_q),
        .compare_val (compare_q),
        .cnt         (cnt_w),
        .cmp_act     (cmp_act_w),
        .match_evt   (match_evt)
    );

    mrt_irq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (match_evt),
        .clr   (wr_status && reg_wdata[0]),
        .flag  (status_q)
    );

    assign irq = status_q && ie_q;

    // Read mux for the register port.
    always_comb begin
        unique case (reg_addr)
            ADDR_W'(ADR_CTRL):    reg_rdata = CNT_W'({ie_q, sel_q, mode_q, run_q});
            ADDR_W'(ADR_RELOAD):  reg_rdata = reload_q;
            ADDR_W'(ADR_COMPARE): reg_rdata = compare_q;
            ADDR_W'(ADR_COUNT):   reg_rdata = cnt_w;
            ADDR_W'(ADR_STATUS):  reg_rdata = CNT_W'(status_q);
            default:              reg_rdata = '0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^{CTL_W, reg_wdata};
endmodule

// File: rtl/mrt_timer_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the timer channel, bound to the top.
// Assumes it observes the top's internal control and counter signals.
module mrt_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic             ctrl_run_bit,
    input logic             irq,
    input logic             run_q,
    input logic             mode_q,
    input logic             status_q,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_act,
    input logic [CNT_W-1:0] reload_q
);
    logic hit;
    assign hit = tick && (cnt == cmp_act);

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !tick) |=> (cnt == $past(cnt)));

    assert_match_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status_q);

    assert_start_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_run_bit && !run_q) |=> (cnt == $past(reload_q)));

    assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !mode_q) |=> !run_q);

    assert_interval_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_q && !ctrl_wr) |=> run_q);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q |-> !irq);

    assert_stopped_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !(ctrl_wr && ctrl_run_bit)) |=> (cnt == $past(cnt)));
endmodule

bind match_reload_timer mrt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (wr_ctrl),
    .ctrl_run_bit (reg_wdata[0]),
    .irq          (irq),
    .run_q        (run_q),
    .mode_q       (mode_q),
    .status_q     (status_q),
    .tick         (tick),
    .cnt          (cnt_w),
    .cmp_act      (cmp_act_w),
    .reload_q     (reload_q)
);

// File: tb/match_reload_timer_tb.sv
`timescale 1ns/1ps
module match_reload_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq;
    int n_chk = 0;
    int n_fail = 0;

    match_reload_timer u_dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq (irq)
    );

    always #4 clk = ~clk;

    // Expected edges from start edge to match edge (R2, R3).
    function automatic int match_edges(input logic [15:0] rl, cp, input int sel);
        logic [15:0] d;
        d = cp - rl;
        return (int'(d) + 1) << sel;
    endfunction

    function automatic logic [15:0] ctrl_word(input bit run, mode, input int sel, input bit ie);
        return 16'({ie, 3'(sel), mode, run});
    endfunction

    task automatic chk(input string req, input logic [15:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] rl, cp, v;
        int sel, tot;
        void'($urandom(32'h5EED_0042));
        waitn(3);
        rst_n = 1'b1;
        #1;
        // R1: reset state of every register and irq
        for (int a = 0; a < 5; a++) chk_reg("R1 reset reg", 3'(a), 16'h0);
        chk("R1 irq low", 16'(irq), 16'h0);
        @(negedge clk);

        // One-shot random runs: R2 R3 R4 R5 R7
        for (int it = 0; it < 8; it++) begin
            rl = 16'($urandom);
            cp = rl + 16'($urandom % 12);
            sel = int'($urandom % 4);
            tot = match_edges(rl, cp, sel);
            wr(3'd1, rl);
            wr(3'd2, cp);
            wr(3'd0, ctrl_word(1, 0, sel, 1));
            chk_reg("R4 start loads reload", 3'd3, rl);
            if (tot > 1) begin
                waitn(tot - 1);
                chk_reg("R3 no early match", 3'd4, 16'h0);
                chk_reg("R2 count before match", 3'd3, rl + 16'((tot - 1) >> sel));
                waitn(1);
            end else waitn(1);
            chk_reg("R3 match sets status", 3'd4, 16'h1);
            chk("R7 irq with enable", 16'(irq), 16'h1);
            chk_reg("R5 one-shot clears run", 3'd0, ctrl_word(0, 0, sel, 1));
            chk_reg("R5 count holds reload", 3'd3, rl);
            wr(3'd4, 16'h0);
            chk_reg("R7 write zero keeps status", 3'd4, 16'h1);
            wr(3'd4, 16'h1);
            chk_reg("R7 w1c clears status", 3'd4, 16'h0);
            chk("R7 irq drops", 16'(irq), 16'h0);
        end

        // Interval random runs: R6 R3
        for (int it = 0; it < 4; it++) begin
            rl = 16'($urandom);
            cp = rl + 16'(1 + $urandom % 10);
            sel = int'($urandom % 3);
            tot = match_edges(rl, cp, sel);
            wr(3'd1, rl);
            wr(3'd2, cp);
            wr(3'd0, ctrl_word(1, 1, sel, 1));
            waitn(tot - 1);
            for (int m = 0; m < 3; m++) begin
                chk_reg("R6 no early match", 3'd4, 16'h0);
                waitn(1);
                chk_reg("R6 periodic match", 3'd4, 16'h1);
                chk_reg("R6 run stays set", 3'd0, ctrl_word(1, 1, sel, 1));
                wr(3'd4, 16'h1);
                waitn(tot - 2);
            end
            wr(3'd0, 16'h0);
            wr(3'd4, 16'h1);
        end

        // R2: prescale by 8 timing from reload 0
        wr(3'd1, 16'h0);
        wr(3'd2, 16'h00FF);
        wr(3'd0, ctrl_word(1, 1, 3, 0));
        waitn(31);
        chk_reg("R2 div8 count at 31", 3'd3, 16'd3);
        waitn(1);
        chk_reg("R2 div8 count at 32", 3'd3, 16'd4);
        wr(3'd0, 16'h0);

        // R3: wrap-around period from 0xFFFE to 0x0001 is 4 ticks
        wr(3'd1, 16'hFFFE);
        wr(3'd2, 16'h0001);
        wr(3'd0, ctrl_word(1, 0, 0, 0));
        waitn(3);
        chk_reg("R3 wrap count", 3'd3, 16'h0001);
        chk_reg("R3 wrap no match yet", 3'd4, 16'h0);
        waitn(1);
        chk_reg("R3 wrap match", 3'd4, 16'h1);
        chk("R7 irq masked when disabled", 16'(irq), 16'h0);
        wr(3'd4, 16'h1);

        // R8: writes during run apply at next reload (sel 1, reload 10, compare 14)
        wr(3'd1, 16'd10);
        wr(3'd2, 16'd14);
        wr(3'd0, ctrl_word(1, 1, 1, 1));
        wr(3'd2, 16'd25);
        wr(3'd1, 16'd22);
        waitn(7);
        chk_reg("R8 old period runs", 3'd4, 16'h0);
        waitn(1);
        chk_reg("R8 first match on old compare", 3'd4, 16'h1);
        chk_reg("R8 new reload used", 3'd3, 16'd22);
        wr(3'd4, 16'h1);
        waitn(6);
        chk_reg("R8 new period count", 3'd3, 16'd25);
        chk_reg("R8 no early second match", 3'd4, 16'h0);
        waitn(1);
        chk_reg("R8 second match on new compare", 3'd4, 16'h1);
        wr(3'd0, 16'h0);
        wr(3'd4, 16'h1);

        // R9: stop holds count (write edge also carries one tick)
        wr(3'd1, 16'd100);
        wr(3'd2, 16'd200);
        wr(3'd0, ctrl_word(1, 1, 0, 0));
        waitn(5);
        chk_reg("R9 running count", 3'd3, 16'd105);
        wr(3'd0, 16'h0);
        chk_reg("R9 count at stop", 3'd3, 16'd106);
        waitn(10);
        chk_reg("R9 count holds", 3'd3, 16'd106);
        rd(3'd4, v);
        chk("R9 no status while stopped", v, 16'h0);

        finish_run();
    end
endmodule